// File: doc/BRIEF.md
# Cascadable Four-Channel Timer Unit

The block holds four 16-bit up-counters that share one system tick enable. Software programs each channel with a reload value, a divider choice, an interrupt enable and a run mode. A running channel either counts divided ticks or, in chained mode, counts only the overflows of the channel just below it. Two or more channels can therefore be chained into one wider counter. When a counter passes its all-ones value it restarts from its reload value, not from zero. It can raise its own interrupt line and can step its upper neighbour.

Overflows of channels 0 and 1 also serve as sample clocks for two streaming-audio channels, A and B. Each of these two channels has a two-bit routing mask that picks which audio channels it feeds. A register write port sets reload, control and routing words. A combinational read port returns the live count of any channel.

Top module: `tq_quad`

## Requirements
- R1: After reset every channel is off, with reload 0, count 0, divider code 0 and interrupts disabled. Channel 0 routes to both audio channels, channel 1 routes to none, and all outputs are low.
- R2: A channel in prescaled mode adds one to its count per completed divider period of `tick_en` cycles. With `tick_en` low its count holds.
- R3: Control bits [1:0] select the divider: code 0 divides by 1, code 1 by 64, code 2 by 256 and code 3 by 1024. The divider restarts from zero when the channel is enabled.
- R4: A step from 16'hFFFF loads the reload value, so reload 16'hFFFF overflows on every step. A reload written (`wr_reg`=0) while the channel runs leaves the count alone and is used at the next overflow.
- R5: A control write (`wr_reg`=1) with bit 7 set to a disabled channel loads the count from the reload value. The same write to an already running channel does not touch the count.
- R6: An overflow of channel i with its interrupt enable (control bit 6) set gives a one-cycle high on `irq[i]` in the cycle after the overflow edge. With the enable clear, `irq[i]` stays low.
- R7: Control bit 2 puts channels 1 to 3 in chained mode. In that mode the channel steps only on the overflow of channel i-1 and ignores the divider and `tick_en`. On channel 0 the bit has no effect.
- R8: Overflows of channels 0 and 1 give one-cycle pulses on `snd_a` when the channel's routing bit 0 is set and on `snd_b` when its routing bit 1 is set (`wr_reg`=2, data bits [1:0]). Routing writes to channels 2 and 3 have no effect.
- R9: A disabled channel (control bit 7 clear) holds its count and never overflows.
- R10: `rd_count` shows the count of channel `rd_ch` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Shared count enable for prescaled channels |
| wr_en | input | 1 | Register write strobe |
| wr_ch | input | 2 | Channel addressed by the write |
| wr_reg | input | 2 | 0 reload, 1 control, 2 audio routing |
| wr_data | input | 16 | Write data |
| rd_ch | input | 2 | Channel whose count is returned |
| rd_count | output | 16 | Live count of `rd_ch` |
| irq | output | 4 | Per-channel interrupt pulses, bit i from channel i |
| snd_a | output | 1 | Sample strobe to audio channel A |
| snd_b | output | 1 | Sample strobe to audio channel B |

## Verification
The assertions check the local rules on every cycle. An interrupt appears only after an enabled overflow. A wrap lands on the reload value held before the edge. A disabled channel holds its count, a chained channel moves only on its neighbour's carry, and each audio strobe traces back to a routed overflow. The bench scenarios show what those rules cannot: exact divider ratios over long runs, the pulse totals of a four-deep chain, the reset routing defaults, and the fact that routing writes to upper channels and the chain bit on channel 0 do nothing.

// File: rtl/tq_pkg.sv
package tq_pkg;

   // register selector on the write port
   typedef enum logic [1:0] {
      REG_RELOAD = 2'd0,
      REG_CTRL   = 2'd1,
      REG_ROUTE  = 2'd2,
      REG_SPARE  = 2'd3
   } tq_reg_e;

   // control word field positions
   localparam int CB_PS   = 0;   // [1:0] divider code
   localparam int CB_CASC = 2;   // chained mode
   localparam int CB_IE   = 6;   // interrupt enable
   localparam int CB_EN   = 7;   // run enable

   typedef enum logic [1:0] {
      MODE_OFF   = 2'd0,
      MODE_PRESC = 2'd1,
      MODE_CASC  = 2'd2
   } tq_mode_e;

   // log2 of the divider selected by a two-bit code
   function automatic int unsigned ps_shift(input logic [1:0] code);
      case (code)
         2'd0:    return 0;
         2'd1:    return 6;
         2'd2:    return 8;
         default: return 10;
      endcase
   endfunction

endpackage

// File: rtl/tq_prescaler.sv
module tq_prescaler
   import tq_pkg::*;
#(
   parameter int PSW = 10
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       run,
   input  logic [1:0] sel,
   output logic       fire
);

   if (PSW < 10) begin : g_bad_psw
      $error("tq_prescaler: PSW must cover a divide by 1024");
   end

   logic [PSW-1:0] acc;
   logic [PSW-1:0] lim;

   always_comb begin
      lim  = PSW'((32'd1 << ps_shift(sel)) - 32'd1);
      fire = run && (acc == lim);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc <= '0;
      end else if (clr) begin
         acc <= '0;
      end else if (run) begin
         acc <= fire ? '0 : acc + 1'b1;
      end
   end

endmodule

// File: rtl/tq_channel.sv
module tq_channel
   import tq_pkg::*;
#(
   parameter int CW  = 16,
   parameter int PSW = 10,
   parameter int IDX = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          sel_wr,
   input  logic [1:0]    wr_reg,
   input  logic [CW-1:0] wr_data,
   input  logic          carry_in,
   output logic          ovf,
   output logic [CW-1:0] cnt,
   output logic [CW-1:0] rld,
   output logic          en,
   output logic          ie,
   output logic          casc
);

   if (CW < 8) begin : g_bad_cw
      $error("tq_channel: CW must hold the control byte");
   end

   localparam bit CAN_CASC = (IDX > 0);

   logic          en_q, ie_q, casc_q;
   logic [1:0]    ps_q;
   logic [CW-1:0] rld_q, cnt_q;
   logic          ctl_wr, rld_wr, load, fire, step;
   tq_mode_e      mode;

   always_comb begin
      ctl_wr = sel_wr && (tq_reg_e'(wr_reg) == REG_CTRL);
      rld_wr = sel_wr && (tq_reg_e'(wr_reg) == REG_RELOAD);
      load   = ctl_wr && !en_q && wr_data[CB_EN];
      if (!en_q)                     mode = MODE_OFF;
      else if (CAN_CASC && casc_q)   mode = MODE_CASC;
      else                           mode = MODE_PRESC;
      case (mode)
         MODE_PRESC: step = fire;
         MODE_CASC:  step = carry_in;
         default:    step = 1'b0;
      endcase
      ovf = step && (&cnt_q);
   end

   tq_prescaler #(.PSW(PSW)) u_ps (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (load),
      .run  (tick && (mode == MODE_PRESC)),
      .sel  (ps_q),
      .fire (fire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         ie_q   <= 1'b0;
         casc_q <= 1'b0;
         ps_q   <= 2'd0;
      end else if (ctl_wr) begin
         en_q   <= wr_data[CB_EN];
         ie_q   <= wr_data[CB_IE];
         casc_q <= wr_data[CB_CASC];
         ps_q   <= wr_data[CB_PS +: 2];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rld_q <= '0;
      else if (rld_wr) rld_q <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (load) cnt_q <= rld_q;
      else if (step) cnt_q <= ovf ? rld_q : cnt_q + 1'b1;
   end

   assign cnt  = cnt_q;
   assign rld  = rld_q;
   assign en   = en_q;
   assign ie   = ie_q;
   assign casc = (mode == MODE_CASC);

endmodule

// File: rtl/tq_route.sv
module tq_route
   import tq_pkg::*;
#(
   parameter int NCH  = 4,
   parameter int NAUD = 2,
   localparam int CHW = $clog2(NCH)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [CHW-1:0]       wr_ch,
   input  logic [1:0]           wr_reg,
   input  logic [1:0]           wr_bits,
   input  logic [NAUD-1:0]      ovf,
   output logic [NAUD-1:0][1:0] mask,
   output logic                 snd_a,
   output logic                 snd_b
);

   logic [NAUD-1:0] hit_a, hit_b;

   for (genvar s = 0; s < NAUD; s++) begin : g_src
      localparam logic [1:0] DEF = (s == 0) ? 2'b11 : 2'b00;
      logic mwr;
      assign mwr = wr_en && (wr_ch == CHW'(s)) && (tq_reg_e'(wr_reg) == REG_ROUTE);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   mask[s] <= DEF;
         else if (mwr) mask[s] <= wr_bits;
      end
      assign hit_a[s] = ovf[s] && mask[s][0];
      assign hit_b[s] = ovf[s] && mask[s][1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snd_a <= 1'b0;
         snd_b <= 1'b0;
      end else begin
         snd_a <= |hit_a;
         snd_b <= |hit_b;
      end
   end

endmodule

// File: rtl/tq_quad.sv
module tq_quad
   import tq_pkg::*;
#(
   parameter int NCH  = 4,
   parameter int CW   = 16,
   parameter int PSW  = 10,
   parameter int NAUD = 2,
   localparam int CHW = $clog2(NCH)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           tick_en,
   input  logic           wr_en,
   input  logic [CHW-1:0] wr_ch,
   input  logic [1:0]     wr_reg,
   input  logic [CW-1:0]  wr_data,
   input  logic [CHW-1:0] rd_ch,
   output logic [CW-1:0]  rd_count,
   output logic [NCH-1:0] irq,
   output logic           snd_a,
   output logic           snd_b
);

   if (NCH < 2) begin : g_bad_nch
      $error("tq_quad: at least two channels are needed");
   end
   if (NAUD < 1 || NAUD > NCH) begin : g_bad_naud
      $error("tq_quad: NAUD must lie in 1..NCH");
   end

   logic [NCH-1:0]          ovf_vec, en_vec, ie_vec, casc_vec, carry;
   logic [NCH-1:0][CW-1:0]  cnt_arr, rld_arr;
   logic [NAUD-1:0][1:0]    route_mask;
   logic [NCH-1:0]          irq_q;

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      if (i == 0) begin : g_head
         assign carry[i] = 1'b0;
      end else begin : g_link
         assign carry[i] = ovf_vec[i-1];
      end

      tq_channel #(.CW(CW), .PSW(PSW), .IDX(i)) u_ch (
         .clk     (clk),
         .rst_n   (rst_n),
         .tick    (tick_en),
         .sel_wr  (wr_en && (wr_ch == CHW'(i))),
         .wr_reg  (wr_reg),
         .wr_data (wr_data),
         .carry_in(carry[i]),
         .ovf     (ovf_vec[i]),
         .cnt     (cnt_arr[i]),
         .rld     (rld_arr[i]),
         .en      (en_vec[i]),
         .ie      (ie_vec[i]),
         .casc    (casc_vec[i])
      );
   end

   tq_route #(.NCH(NCH), .NAUD(NAUD)) u_route (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_ch  (wr_ch),
      .wr_reg (wr_reg),
      .wr_bits(wr_data[1:0]),
      .ovf    (ovf_vec[NAUD-1:0]),
      .mask   (route_mask),
      .snd_a  (snd_a),
      .snd_b  (snd_b)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= '0;
      else        irq_q <= ovf_vec & ie_vec;
   end

   assign irq      = irq_q;
   assign rd_count = cnt_arr[rd_ch];

endmodule

// File: rtl/tq_quad_chk.sv
module tq_quad_chk #(
   parameter int NCH  = 4,
   parameter int CW   = 16,
   parameter int NAUD = 2
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [NCH-1:0]         irq,
   input logic                   snd_a,
   input logic                   snd_b,
   input logic [NCH-1:0]         ovf_vec,
   input logic [NCH-1:0]         en_vec,
   input logic [NCH-1:0]         ie_vec,
   input logic [NCH-1:0]         casc_vec,
   input logic [NCH-1:0][CW-1:0] cnt_arr,
   input logic [NCH-1:0][CW-1:0] rld_arr,
   input logic [NAUD-1:0][1:0]   route_mask
);

   logic src_a, src_b;
   always_comb begin
      src_a = 1'b0;
      src_b = 1'b0;
      for (int s = 0; s < NAUD; s++) begin
         src_a = src_a | (ovf_vec[s] & route_mask[s][0]);
         src_b = src_b | (ovf_vec[s] & route_mask[s][1]);
      end
   end

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      assert_irq_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
         irq[i] |-> ($past(ie_vec[i]) && $past(ovf_vec[i])));

      assert_wrap_to_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
         ovf_vec[i] |=> (cnt_arr[i] == $past(rld_arr[i])));

      assert_off_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
         !en_vec[i] |=> ((cnt_arr[i] == $past(cnt_arr[i])) || en_vec[i]));

      if (i > 0) begin : g_link
         assert_chain_on_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (casc_vec[i] && !ovf_vec[i-1]) |=> (cnt_arr[i] == $past(cnt_arr[i])));
      end
   end

   assert_snd_a_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
      snd_a |-> $past(src_a));

   assert_snd_b_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
      snd_b |-> $past(src_b));

endmodule

bind tq_quad tq_quad_chk #(.NCH(NCH), .CW(CW), .NAUD(NAUD)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .irq       (irq),
   .snd_a     (snd_a),
   .snd_b     (snd_b),
   .ovf_vec   (ovf_vec),
   .en_vec    (en_vec),
   .ie_vec    (ie_vec),
   .casc_vec  (casc_vec),
   .cnt_arr   (cnt_arr),
   .rld_arr   (rld_arr),
   .route_mask(route_mask)
);

// File: tb/sim_tq_quad.sv
`timescale 1ns/1ps
module sim_tq_quad;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_ch = '0;
   logic [1:0]  wr_reg = '0;
   logic [15:0] wr_data = '0;
   logic [1:0]  rd_ch = '0;
   logic [15:0] rd_count;
   logic [3:0]  irq;
   logic        snd_a, snd_b;

   always #10 clk = ~clk;   // 50 MHz

   tq_quad u0 (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
      .wr_ch(wr_ch), .wr_reg(wr_reg), .wr_data(wr_data), .rd_ch(rd_ch),
      .rd_count(rd_count), .irq(irq), .snd_a(snd_a), .snd_b(snd_b)
   );

   localparam int K_CNT = 0, K_IRQ = 1, K_SA = 2, K_SB = 3, K_CLR = 4, K_OUT = 5;

   // scoreboard queues
   string tag_q[$];
   int    kind_q[$];
   int    idx_q[$];
   int    val_q[$];

   int checks = 0;
   int errors = 0;
   int irq_n[4];
   int sa_n, sb_n;
   bit done = 1'b0;

   task automatic push(input string tag, input int kind, input int idx, input int val);
      tag_q.push_back(tag); kind_q.push_back(kind);
      idx_q.push_back(idx); val_q.push_back(val);
   endtask

   task automatic cmp(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: %s actual 0x%0h expected 0x%0h", tag, what, act, exp);
      end
   endtask

   // monitor: counts pulses and pops expected items
   initial begin
      forever begin
         @(posedge clk);
         #5;
         if (rst_n) begin
            for (int i = 0; i < 4; i++) irq_n[i] += int'(irq[i]);
            sa_n += int'(snd_a);
            sb_n += int'(snd_b);
            while (tag_q.size() > 0) begin
               string t; int k, x, v;
               t = tag_q.pop_front(); k = kind_q.pop_front();
               x = idx_q.pop_front(); v = val_q.pop_front();
               case (k)
                  K_CNT: cmp(t, $sformatf("count ch%0d", x), int'(rd_count), v);
                  K_IRQ: cmp(t, $sformatf("irq%0d pulses", x), irq_n[x], v);
                  K_SA:  cmp(t, "snd_a pulses", sa_n, v);
                  K_SB:  cmp(t, "snd_b pulses", sb_n, v);
                  K_OUT: cmp(t, "irq,snd_a,snd_b", int'({irq, snd_a, snd_b}), v);
                  default: begin
                     for (int i = 0; i < 4; i++) irq_n[i] = 0;
                     sa_n = 0; sb_n = 0;
                  end
               endcase
            end
         end
      end
   end

   // driver tasks
   task automatic wr(input int ch, input logic [1:0] r, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_ch = ch[1:0]; wr_reg = r; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic exp_cnt(input string tag, input int ch, input int v);
      @(negedge clk);
      rd_ch = ch[1:0];
      push(tag, K_CNT, ch, v);
   endtask

   task automatic exp_pulses(input string tag, input int i0, input int i1,
                             input int i2, input int i3, input int a, input int b);
      @(negedge clk);
      push(tag, K_IRQ, 0, i0); push(tag, K_IRQ, 1, i1);
      push(tag, K_IRQ, 2, i2); push(tag, K_IRQ, 3, i3);
      push(tag, K_SA, 0, a);   push(tag, K_SB, 0, b);
   endtask

   task automatic clr_pulses();
      @(negedge clk);
      push("", K_CLR, 0, 0);
   endtask

   task automatic run_ticks(input int n);
      @(negedge clk);
      tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
   endtask

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: run did not end, actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      for (int c = 0; c < 4; c++) exp_cnt("R1", c, 0);
      @(negedge clk); push("R1", K_OUT, 0, 0);

      // R5/R2/R4/R6/R8: ch0 reload FFFC, div1, irq on, default routing
      wr(0, 2'd0, 16'hFFFC);
      wr(0, 2'd1, 16'h00C0);
      exp_cnt("R5", 0, 16'hFFFC);
      repeat (5) @(negedge clk);
      exp_cnt("R2", 0, 16'hFFFC);          // tick low holds
      clr_pulses();
      run_ticks(40);
      exp_pulses("R6", 10, 0, 0, 0, 10, 10);
      exp_pulses("R8", 10, 0, 0, 0, 10, 10);  // ch0 routes to A and B by default
      exp_cnt("R4", 0, 16'hFFFC);

      // R4: back-to-back overflows with reload FFFF on ch1
      wr(0, 2'd1, 16'h0000);
      wr(1, 2'd0, 16'hFFFF);
      wr(1, 2'd1, 16'h00C0);
      clr_pulses();
      run_ticks(8);
      exp_pulses("R4", 0, 8, 0, 0, 0, 0);   // ch1 routes nowhere by default (R8)
      exp_cnt("R4", 1, 16'hFFFF);
      @(negedge clk); push("R6", K_OUT, 0, 0);

      // R3: all three non-trivial dividers at once
      wr(1, 2'd1, 16'h0000);
      wr(1, 2'd0, 16'h0000);
      wr(2, 2'd0, 16'h0000);
      wr(3, 2'd0, 16'h0000);
      wr(1, 2'd1, 16'h0083);
      wr(2, 2'd1, 16'h0081);
      wr(3, 2'd1, 16'h0082);
      run_ticks(2100);
      exp_cnt("R3", 1, 2);
      exp_cnt("R3", 2, 32);
      exp_cnt("R3", 3, 8);
      exp_cnt("R9", 0, 16'hFFFC);          // disabled ch0 untouched

      // R5: control write to a running channel keeps the count
      wr(2, 2'd1, 16'h0081);
      exp_cnt("R5", 2, 32);
      // R4: reload write while running keeps the count
      wr(2, 2'd0, 16'h1234);
      exp_cnt("R4", 2, 32);

      // R4: new reload used at next overflow
      wr(0, 2'd1, 16'h0080);
      wr(0, 2'd0, 16'h0100);
      exp_cnt("R4", 0, 16'hFFFC);
      run_ticks(4);
      exp_cnt("R4", 0, 16'h0100);

      // R7/R8: four-deep chain with routing
      for (int c = 0; c < 4; c++) wr(c, 2'd1, 16'h0000);
      for (int c = 0; c < 4; c++) wr(c, 2'd0, 16'hFFFE);
      wr(0, 2'd2, 16'h0002);   // ch0 -> B only
      wr(1, 2'd2, 16'h0001);   // ch1 -> A only
      wr(2, 2'd2, 16'h0003);   // ignored
      wr(3, 2'd2, 16'h0003);   // ignored
      wr(3, 2'd1, 16'h00C4);
      wr(2, 2'd1, 16'h00C4);
      wr(1, 2'd1, 16'h0087);   // chained, divider code ignored
      wr(0, 2'd1, 16'h0084);   // chain bit ignored on ch0
      clr_pulses();
      run_ticks(32);
      exp_pulses("R7", 0, 0, 4, 2, 8, 16);
      exp_pulses("R8", 0, 0, 4, 2, 8, 16);
      for (int c = 0; c < 4; c++) exp_cnt("R7", c, 16'hFFFE);
      exp_cnt("R10", 3, 16'hFFFE);

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule